// File: doc/BRIEF.md
# Serial Configuration Register Bank

This block takes 24-bit configuration words over a three-wire write-only port (serial clock, serial data, load strobe) and keeps them in four internal registers: reference divider setup, feedback divider setup, function setup and initialization. The three pins are sampled in the system clock domain. Bits shift in most significant first, one on each rising edge of the serial clock. On the rising edge of the load strobe, the two lowest bits of the shifted word pick the destination register.

The decoded fields come out as registered outputs, which drive the divider, phase detector and charge pump control logic elsewhere on the chip. The block also sequences the one-cycle counter-reset pulse. An initialization write fires the pulse. The first feedback divider write after that initialization fires it one more time. No other write fires it.

Top module: `cfg_serial_bank`

## Requirements
- R1: Each rising edge of `ser_clk` shifts `ser_data` into a 24-bit register, most significant bit first. On a rising edge of `ser_le`, only the last 24 bits shifted in are used, and bits [1:0] of that word select the destination: 0 = reference, 1 = feedback, 2 = function, 3 = initialization.
- R2: A reference write (address 0) loads `ref_div` from word bits [15:2], `ref_abw` from [17:16], `ref_test` from [19:18] and `ref_lock_prec` from bit [20].
- R3: A feedback write (address 1) loads `fb_div` from word bits [20:8] and `fb_gain` from bit [21].
- R4: A function write (address 2) loads `fn_cfg` from word bits [23:2]. `cnt_hold` equals bit 2 of the stored function word. A function write fires no counter-reset pulse.
- R5: An initialization write (address 3) loads the same function fields as R4 and fires `cnt_rst_pulse` high for exactly one system clock cycle.
- R6: The first feedback write after an initialization write fires one further one-cycle pulse. Later feedback writes fire none until the next initialization write. Feedback writes made after reset but before any initialization write fire none.
- R7: A feedback write whose ratio field is 0 is stored unchanged and sets `fb_div_err` to 1. A later feedback write with a nonzero ratio clears the flag.
- R8: A write to one address leaves the outputs of the other registers unchanged. Shifting without a load strobe changes no output.
- R9: After asynchronous reset, every register output, `fb_div_err` and `cnt_rst_pulse` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial shift clock |
| ser_data | input | 1 | Serial data, MSB first |
| ser_le | input | 1 | Load strobe, rising edge latches the word |
| ref_div | output | 14 | Reference divide ratio |
| ref_abw | output | 2 | Anti-backlash width code |
| ref_test | output | 2 | Test mode bits |
| ref_lock_prec | output | 1 | Lock detect precision select |
| fb_div | output | 13 | Feedback divide ratio |
| fb_gain | output | 1 | Charge pump gain select |
| fb_div_err | output | 1 | Last feedback ratio written was 0 |
| fn_cfg | output | 22 | Function word bits [23:2] |
| cnt_hold | output | 1 | Counters held at load state |
| cnt_rst_pulse | output | 1 | One-cycle counter reset pulse |

## Verification
Each address gets a word with distinct values in its fields, so a field taken from the wrong bit position or from the wrong register shows up. The bench counts pulses over a sequence: feedback write before any initialization, initialization, first feedback write, second feedback write, function write, then initialization and feedback again. This separates the armed state from one-shot and free-running pulse behaviour. A zero ratio followed by a nonzero ratio checks that the error flag both sets and clears. A word longer than 24 bits checks that only the last 24 bits shifted in are used. Shifting with no load strobe checks that the outputs hold.

// File: rtl/cfg_pkg.sv
package cfg_pkg;
  localparam int WORD_W = 24;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    ADR_REF  = 2'd0,
    ADR_FB   = 2'd1,
    ADR_FN   = 2'd2,
    ADR_INIT = 2'd3
  } cfg_addr_e;
endpackage

// File: rtl/cfg_pin_sync.sv
module cfg_pin_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] lvl_o,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] stg_q [STAGES];
  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q[0] <= '0;
    else        stg_q[0] <= pin_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q[s] <= '0;
      else        stg_q[s] <= stg_q[s-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= stg_q[STAGES-1];
  end

  assign lvl_o  = stg_q[STAGES-1];
  assign rise_o = stg_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/cfg_shift.sv
module cfg_shift
  import cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic              bit_i,
  output logic [WORD_W-1:0] word_o
);
  logic [WORD_W-1:0] sh_q, sh_d;

  always_comb begin
    sh_d = sh_q;
    if (shift_en) sh_d = {sh_q[WORD_W-2:0], bit_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign word_o = sh_q;

  p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(sh_q));
endmodule

// File: rtl/cfg_latch_bank.sv
module cfg_latch_bank
  import cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [WORD_W-1:0] word_i,
  output logic [13:0]       ref_div,
  output logic [1:0]        ref_abw,
  output logic [1:0]        ref_test,
  output logic              ref_lock_prec,
  output logic [12:0]       fb_div,
  output logic              fb_gain,
  output logic              fb_div_err,
  output logic [WORD_W-3:0] fn_cfg,
  output logic              cnt_rst_pulse
);
  localparam int REF_LO = 2,  REF_HI = 20;
  localparam int FB_LO  = 8,  FB_HI  = 21;
  localparam int FN_LO  = ADDR_W;

  cfg_addr_e addr;
  logic [REF_HI-REF_LO:0] ref_q, ref_d;
  logic [FB_HI-FB_LO:0]   fb_q, fb_d;
  logic [WORD_W-3:0]      fn_q, fn_d;
  logic err_q, err_d, armed_q, armed_d, pulse_q, pulse_d;

  assign addr = cfg_addr_e'(word_i[ADDR_W-1:0]);

  always_comb begin
    ref_d   = ref_q;
    fb_d    = fb_q;
    fn_d    = fn_q;
    err_d   = err_q;
    armed_d = armed_q;
    pulse_d = 1'b0;
    if (load_en) begin
      unique case (addr)
        ADR_REF: ref_d = word_i[REF_HI:REF_LO];
        ADR_FB: begin
          fb_d  = word_i[FB_HI:FB_LO];
          err_d = (word_i[FB_HI-1:FB_LO] == '0);
          if (armed_q) begin
            pulse_d = 1'b1;
            armed_d = 1'b0;
          end
        end
        ADR_FN: fn_d = word_i[WORD_W-1:FN_LO];
        ADR_INIT: begin
          fn_d    = word_i[WORD_W-1:FN_LO];
          pulse_d = 1'b1;
          armed_d = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q   <= '0;
      fb_q    <= '0;
      fn_q    <= '0;
      err_q   <= 1'b0;
      armed_q <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      ref_q   <= ref_d;
      fb_q    <= fb_d;
      fn_q    <= fn_d;
      err_q   <= err_d;
      armed_q <= armed_d;
      pulse_q <= pulse_d;
    end
  end

  assign ref_div       = ref_q[13:0];
  assign ref_abw       = ref_q[15:14];
  assign ref_test      = ref_q[17:16];
  assign ref_lock_prec = ref_q[18];
  assign fb_div        = fb_q[12:0];
  assign fb_gain       = fb_q[13];
  assign fb_div_err    = err_q;
  assign fn_cfg        = fn_q;
  assign cnt_rst_pulse = pulse_q;

  p_pulse_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q |=> !pulse_q);
  p_pulse_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q |-> $past(load_en));
  p_ref_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !load_en |=> ($stable(ref_q) && $stable(fb_q) && $stable(fn_q)));
  p_err_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (load_en && addr == ADR_FB) |=> (fb_div_err == (fb_div == '0)));
endmodule

// File: rtl/cfg_serial_bank.sv
module cfg_serial_bank
  import cfg_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ser_clk,
  input  logic        ser_data,
  input  logic        ser_le,
  output logic [13:0] ref_div,
  output logic [1:0]  ref_abw,
  output logic [1:0]  ref_test,
  output logic        ref_lock_prec,
  output logic [12:0] fb_div,
  output logic        fb_gain,
  output logic        fb_div_err,
  output logic [21:0] fn_cfg,
  output logic        cnt_hold,
  output logic        cnt_rst_pulse
);
  localparam int PIN_N = 3;

  logic [1:0] rst_sq;
  logic       rst_sn;
  logic [PIN_N-1:0] lvl, rise;
  logic [WORD_W-1:0] word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sq <= '0;
    else        rst_sq <= {rst_sq[0], 1'b1};
  end
  assign rst_sn = rst_sq[1];

  cfg_pin_sync #(.W(PIN_N), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_sn),
    .pin_i({ser_le, ser_data, ser_clk}),
    .lvl_o(lvl), .rise_o(rise)
  );

  cfg_shift u_shift (
    .clk(clk), .rst_n(rst_sn),
    .shift_en(rise[0]), .bit_i(lvl[1]), .word_o(word)
  );

  cfg_latch_bank u_bank (
    .clk(clk), .rst_n(rst_sn),
    .load_en(rise[2]), .word_i(word),
    .ref_div(ref_div), .ref_abw(ref_abw), .ref_test(ref_test),
    .ref_lock_prec(ref_lock_prec), .fb_div(fb_div), .fb_gain(fb_gain),
    .fb_div_err(fb_div_err), .fn_cfg(fn_cfg), .cnt_rst_pulse(cnt_rst_pulse)
  );

  assign cnt_hold = fn_cfg[0];

  p_hold_tracks_r4: assert property (@(posedge clk) disable iff (!rst_sn)
    !rise[2] |=> $stable(cnt_hold));
endmodule

// File: tb/cfg_serial_bank_tb_top.sv
module cfg_serial_bank_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ser_clk = 1'b0, ser_data = 1'b0, ser_le = 1'b0;
  logic [13:0] ref_div; logic [1:0] ref_abw, ref_test; logic ref_lock_prec;
  logic [12:0] fb_div; logic fb_gain, fb_div_err;
  logic [21:0] fn_cfg; logic cnt_hold, cnt_rst_pulse;
  int total = 0, bad = 0, pulses = 0;

  always #5 clk = ~clk;

  cfg_serial_bank dut_i (.*);

  always @(negedge clk) if (rst_n && cnt_rst_pulse) pulses++;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [31:0] w, input int n = 24);
    for (int i = n - 1; i >= 0; i--) begin
      ser_data = w[i];
      repeat (4) @(negedge clk);
      ser_clk = 1'b1;
      repeat (4) @(negedge clk);
      ser_clk = 1'b0;
    end
    repeat (4) @(negedge clk);
    ser_le = 1'b1;
    repeat (4) @(negedge clk);
    ser_le = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  function automatic logic [23:0] fbw(input logic g, input logic [12:0] d);
    return {2'b00, g, d, 6'b0, 2'b01};
  endfunction

  task automatic t_reset;
    chk("R9 ref_div", ref_div, 0);
    chk("R9 fb_div", fb_div, 0);
    chk("R9 fn_cfg", fn_cfg, 0);
    chk("R9 err", fb_div_err, 0);
    chk("R9 pulse", cnt_rst_pulse, 0);
  endtask

  task automatic t_ref;
    send({3'b000, 1'b1, 2'd2, 2'd1, 14'h1234, 2'b00});
    chk("R2 ref_div", ref_div, 14'h1234);
    chk("R2 ref_abw", ref_abw, 1);
    chk("R2 ref_test", ref_test, 2);
    chk("R2 ref_lock_prec", ref_lock_prec, 1);
    chk("R8 fb untouched", fb_div, 0);
  endtask

  task automatic t_fb_unarmed;
    pulses = 0;
    send(fbw(1'b1, 13'h0ABC));
    chk("R3 fb_div", fb_div, 13'h0ABC);
    chk("R3 fb_gain", fb_gain, 1);
    chk("R6 no pulse before init", pulses, 0);
    chk("R8 ref untouched", ref_div, 14'h1234);
  endtask

  task automatic t_func;
    pulses = 0;
    send({22'h2A5A5F, 2'b10});
    chk("R4 fn_cfg", fn_cfg, 22'h2A5A5F);
    chk("R4 cnt_hold", cnt_hold, 1);
    chk("R4 no pulse", pulses, 0);
  endtask

  task automatic t_init_seq;
    pulses = 0;
    send({22'h155550, 2'b11});
    chk("R5 fn_cfg", fn_cfg, 22'h155550);
    chk("R5 cnt_hold", cnt_hold, 0);
    chk("R5 one pulse", pulses, 1);
    pulses = 0;
    send(fbw(1'b0, 13'd7));
    chk("R6 first fb pulse", pulses, 1);
    pulses = 0;
    send(fbw(1'b0, 13'd9));
    chk("R6 second fb none", pulses, 0);
    send({22'h000001, 2'b10});
    send(fbw(1'b0, 13'd11));
    chk("R6 fn does not rearm", pulses, 0);
    send({22'h000002, 2'b11});
    send(fbw(1'b0, 13'd12));
    chk("R6 rearm after init", pulses, 2);
  endtask

  task automatic t_zero;
    send(fbw(1'b1, 13'd0));
    chk("R7 zero stored", fb_div, 0);
    chk("R7 zero flagged", fb_div_err, 1);
    send(fbw(1'b0, 13'd5));
    chk("R7 flag cleared", fb_div_err, 0);
  endtask

  task automatic t_long_and_idle;
    send({8'hFF, 1'b0, 1'b0, 2'd3, 2'd2, 14'h0321, 2'b00}, 32);
    chk("R1 last 24 bits", ref_div, 14'h0321);
    chk("R1 abw", ref_abw, 2);
    for (int i = 0; i < 6; i++) begin
      ser_data = 1'b1;
      repeat (4) @(negedge clk); ser_clk = 1'b1;
      repeat (4) @(negedge clk); ser_clk = 1'b0;
    end
    repeat (6) @(negedge clk);
    chk("R8 shift only ref", ref_div, 14'h0321);
    chk("R8 shift only fn", fn_cfg, 22'h000002);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_ref();
    t_fb_unarmed();
    t_func();
    t_init_seq();
    t_zero();
    t_long_and_idle();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule